// File: doc/BRIEF.md
# Stream and Adjacent-Line Data Prefetcher

This block watches the stream of second-level cache accesses and turns them into hardware prefetch requests toward memory. Each access event carries a byte address, an access kind and a hit/miss flag. Two engines work from the same event. The first is a stream detector. It keeps separate pools for ascending and descending streams, starts a stream when two training misses land close together, and advances that stream whenever a training access reaches the line the stream expects next. The second engine completes the 128-byte aligned pair on every training miss by asking for the partner 64-byte line.

Candidates are stored in a small pending queue. The queue filters duplicate lines and presents its oldest entry on a valid/ready request port into the shared bus queue. Prefetches always give way to demand traffic. When the shared bus queue fills past a high-water mark, new candidates are dropped and queued ones are flushed, oldest first. Stores that miss and need a read for ownership, and software prefetch hints, train the engines in the same way as loads.

Top module: `l2_stream_prefetcher`

## Requirements
- R1: After reset the request port is idle (`pf_valid` low), the pending queue is empty, no stream is active and no previous miss is remembered.
- R2: Every training miss enqueues the partner line, which is the miss address with bit 6 inverted and bits 5:0 cleared. With an empty queue and no blocking, it appears on `pf_addr` with `pf_valid` high in the cycle after the access.
- R3: A training miss that is `TRIG_DIST` lines or fewer above the previous training miss allocates an ascending stream and requests line+1. If it is that close below, it allocates a descending stream and requests line-1. An equal line, or a line further away, allocates nothing. The allocating miss then becomes the previous miss.
- R4: A training access, hit or miss, whose line equals a stream's expected line requests the next line in the stream's direction and moves the expectation one line further. Ascending streams are searched first, and within a pool the lowest entry wins.
- R5: The ascending pool holds 16 streams and the descending pool holds 4. Allocation takes the lowest unused entry first. When none is unused, it replaces the least recently allocated or advanced entry of that pool.
- R6: A stream request whose line lies outside the 4 KB page of the access is suppressed, but the stream still advances.
- R7: Access kinds 0 (load), 1 (store missing with read for ownership) and 2 (software prefetch hint) train identically. Kind 3 has no effect on streams, on the previous-miss record or on the queue.
- R8: While `dem_pending` is high, `pf_valid` is low and the queue head is kept.
- R9: While `busq_level` exceeds `HWM`, `pf_valid` is low, new candidates are discarded, and one queued entry, the oldest, is discarded per cycle.
- R10: A candidate whose line is already queued is not enqueued again. The partner line is skipped when it equals the stream request. The stream request enqueues before the partner line, and candidates that find the queue full are dropped.
- R11: The head is removed when `pf_valid` and `pf_ready` are both high. Entries leave in arrival order, and an unaccepted head holds its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access event present |
| acc_addr | input | AW | Byte address of the access |
| acc_kind | input | 2 | 0 load, 1 RFO store, 2 software prefetch, 3 non-training |
| acc_miss | input | 1 | Access missed the cache |
| dem_pending | input | 1 | Demand request occupies the bus queue port this cycle |
| busq_level | input | LVLW | Occupancy of the shared bus request queue |
| pf_ready | input | 1 | Bus queue accepts the prefetch request |
| pf_valid | output | 1 | Prefetch request present |
| pf_addr | output | AW | Line-aligned prefetch byte address |

## Verification
Every candidate is due exactly one cycle after the access that creates it, because training, filtering and enqueue all complete at the same edge. The port itself is combinational on `dem_pending`, `busq_level` and the queue head, so yielding and blocking take effect in the same cycle. The bench drives inputs just after the falling edge, samples the port 8 ns later before the rising edge, and then advances its own reference model by one edge. Each comparison is therefore made against the state that the preceding edges produced.

// File: rtl/pf_pkg.sv
package pf_pkg;
   typedef enum logic [1:0] {
      ACC_LOAD    = 2'd0,
      ACC_RFO     = 2'd1,
      ACC_SWPF    = 2'd2,
      ACC_NOTRAIN = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/pf_stream_pool.sv
module pf_stream_pool #(
   parameter int N      = 16,
   parameter int LW     = 26,
   parameter bit ASCEND = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          look_v,
   input  logic [LW-1:0] look_line,
   input  logic          take,
   input  logic          alloc,
   output logic          hit
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   logic [LW-1:0] nxt_q [N];
   logic [N-1:0]  vld_q;
   logic [IW-1:0] age_q [N];
   logic [N-1:0]  match;
   logic [IW-1:0] hit_idx, vic_idx, tch_idx;
   logic          tch;
   logic [LW-1:0] step_line;

   if (N < 1) begin : g_bad_n
      $error("pf_stream_pool: N must be at least 1");
   end

   // direction variant: the expectation moves one line up or down
   if (ASCEND) begin : g_up
      assign step_line = look_line + 1'b1;
   end else begin : g_dn
      assign step_line = look_line - 1'b1;
   end

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign match[i] = vld_q[i] && (nxt_q[i] == look_line);
   end

   always_comb begin
      hit_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match[i]) hit_idx = IW'(i);
      end
      vic_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (age_q[i] == IW'(N - 1)) vic_idx = IW'(i);
      end
   end

   assign hit     = look_v && (|match);
   assign tch     = (hit && take) || alloc;
   assign tch_idx = alloc ? vic_idx : hit_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < N; i++) begin
            nxt_q[i] <= '0;
            age_q[i] <= IW'(N - 1 - i);
         end
      end else if (tch) begin
         for (int i = 0; i < N; i++) begin
            if (IW'(i) == tch_idx) begin
               age_q[i] <= '0;
               nxt_q[i] <= step_line;
               vld_q[i] <= 1'b1;
            end else if (age_q[i] < age_q[tch_idx]) begin
               age_q[i] <= age_q[i] + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pf_pend_queue.sv
module pf_pend_queue #(
   parameter int QD  = 4,
   parameter int LW  = 26,
   parameter int QCW = $clog2(QD + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           drop_mode,
   input  logic           pop,
   input  logic           c0_v,
   input  logic [LW-1:0]  c0_line,
   input  logic           c1_v,
   input  logic [LW-1:0]  c1_line,
   output logic [LW-1:0]  head_line,
   output logic [QCW-1:0] cnt
);
   logic [LW-1:0]  q_line [QD];
   logic [QCW-1:0] cnt_q;
   logic [QD-1:0]  eq0, eq1;
   logic           dup0, dup1, w0, w1, rm;
   logic [LW-1:0]  nl [QD];
   logic [QCW-1:0] nc;

   for (genvar i = 0; i < QD; i++) begin : g_dup
      assign eq0[i] = (QCW'(i) < cnt_q) && (q_line[i] == c0_line);
      assign eq1[i] = (QCW'(i) < cnt_q) && (q_line[i] == c1_line);
   end

   assign dup0 = |eq0;
   assign dup1 = |eq1;
   assign w0   = c0_v && !drop_mode && !dup0;
   assign w1   = c1_v && !drop_mode && !dup1 && !(c0_v && (c1_line == c0_line));
   assign rm   = (pop || drop_mode) && (cnt_q != '0);

   always_comb begin
      nc = cnt_q;
      for (int i = 0; i < QD; i++) nl[i] = q_line[i];
      if (rm) begin
         for (int i = 0; i < QD - 1; i++) nl[i] = q_line[i + 1];
         nc = cnt_q - 1'b1;
      end
      if (w0 && (nc < QCW'(QD))) begin
         for (int i = 0; i < QD; i++) begin
            if (QCW'(i) == nc) nl[i] = c0_line;
         end
         nc = nc + 1'b1;
      end
      if (w1 && (nc < QCW'(QD))) begin
         for (int i = 0; i < QD; i++) begin
            if (QCW'(i) == nc) nl[i] = c1_line;
         end
         nc = nc + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < QD; i++) q_line[i] <= '0;
      end else begin
         cnt_q <= nc;
         for (int i = 0; i < QD; i++) q_line[i] <= nl[i];
      end
   end

   assign head_line = q_line[0];
   assign cnt       = cnt_q;
endmodule

// File: rtl/l2_stream_prefetcher.sv
module l2_stream_prefetcher
   import pf_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LINE_B    = 6,
   parameter int PAGE_B    = 12,
   parameter int FWD_N     = 16,
   parameter int BWD_N     = 4,
   parameter int TRIG_DIST = 4,
   parameter int QD        = 4,
   parameter int LVLW      = 4,
   parameter int HWM       = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_valid,
   input  logic [AW-1:0]   acc_addr,
   input  logic [1:0]      acc_kind,
   input  logic            acc_miss,
   input  logic            dem_pending,
   input  logic [LVLW-1:0] busq_level,
   input  logic            pf_ready,
   output logic            pf_valid,
   output logic [AW-1:0]   pf_addr
);
   localparam int LW  = AW - LINE_B;
   localparam int PGL = PAGE_B - LINE_B;
   localparam int QCW = $clog2(QD + 1);

   if (PAGE_B <= LINE_B || PAGE_B >= AW) begin : g_bad_page
      $error("l2_stream_prefetcher: page must be wider than a line and narrower than the address");
   end
   if (TRIG_DIST < 1) begin : g_bad_dist
      $error("l2_stream_prefetcher: TRIG_DIST must be at least 1");
   end
   if (QD < 2) begin : g_bad_qd
      $error("l2_stream_prefetcher: QD must hold both candidates of one access");
   end
   if (HWM >= (1 << LVLW)) begin : g_bad_hwm
      $error("l2_stream_prefetcher: HWM must be reachable by busq_level");
   end

   acc_kind_e      kind;
   logic           train, tmiss, over;
   logic [LW-1:0]  line, last_q;
   logic           last_v_q;
   logic           near_up, near_dn;
   logic           fwd_hit, bwd_hit, fwd_alloc, bwd_alloc;
   logic           s_up, s_dn, s_vld;
   logic [LW-1:0]  s_line, a_line, head_line;
   logic [QCW-1:0] q_cnt;
   logic           unused_lo;

   assign kind      = acc_kind_e'(acc_kind);
   assign unused_lo = ^acc_addr[LINE_B-1:0];
   assign line      = acc_addr[AW-1:LINE_B];
   assign train     = acc_valid && (kind != ACC_NOTRAIN);
   assign tmiss     = train && acc_miss;
   assign over      = busq_level > LVLW'(HWM);

   assign near_up = last_v_q && (line > last_q) && ((line - last_q) <= LW'(TRIG_DIST));
   assign near_dn = last_v_q && (line < last_q) && ((last_q - line) <= LW'(TRIG_DIST));

   assign fwd_alloc = tmiss && !fwd_hit && !bwd_hit && near_up;
   assign bwd_alloc = tmiss && !fwd_hit && !bwd_hit && near_dn;

   pf_stream_pool #(.N(FWD_N), .LW(LW), .ASCEND(1'b1)) u_fwd (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_v    (train),
      .look_line (line),
      .take      (1'b1),
      .alloc     (fwd_alloc),
      .hit       (fwd_hit)
   );

   pf_stream_pool #(.N(BWD_N), .LW(LW), .ASCEND(1'b0)) u_bwd (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_v    (train),
      .look_line (line),
      .take      (!fwd_hit),
      .alloc     (bwd_alloc),
      .hit       (bwd_hit)
   );

   assign s_up   = fwd_hit || fwd_alloc;
   assign s_dn   = (bwd_hit && !fwd_hit) || bwd_alloc;
   assign s_line = s_up ? (line + 1'b1) : (line - 1'b1);
   assign s_vld  = (s_up || s_dn) && (s_line[LW-1:PGL] == line[LW-1:PGL]);
   assign a_line = {line[LW-1:1], ~line[0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_v_q <= 1'b0;
         last_q   <= '0;
      end else if (tmiss) begin
         last_v_q <= 1'b1;
         last_q   <= line;
      end
   end

   pf_pend_queue #(.QD(QD), .LW(LW), .QCW(QCW)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .drop_mode (over),
      .pop       (pf_valid && pf_ready),
      .c0_v      (s_vld),
      .c0_line   (s_line),
      .c1_v      (tmiss),
      .c1_line   (a_line),
      .head_line (head_line),
      .cnt       (q_cnt)
   );

   assign pf_valid = (q_cnt != '0) && !dem_pending && !over;
   assign pf_addr  = {head_line, {LINE_B{1'b0}}};
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
   parameter int AW   = 32,
   parameter int LVLW = 4,
   parameter int HWM  = 12,
   parameter int QCW  = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            acc_valid,
   input logic [1:0]      acc_kind,
   input logic            acc_miss,
   input logic            dem_pending,
   input logic [LVLW-1:0] busq_level,
   input logic            pf_ready,
   input logic            pf_valid,
   input logic [AW-1:0]   pf_addr,
   input logic [QCW-1:0]  q_cnt
);
   logic over;
   assign over = busq_level > LVLW'(HWM);

   a_r8_demand_yield: assert property (@(posedge clk) disable iff (!rst_n)
      dem_pending |-> !pf_valid);

   a_r9_hwm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      over |-> !pf_valid);

   a_r11_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !pf_ready) |=> (pf_addr == $past(pf_addr)));

   a_r2_partner_queued: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_miss && acc_kind != 2'd3 && q_cnt == '0 && !over) |=> (q_cnt != '0));

   a_r7_notrain_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_kind == 2'd3 && q_cnt == '0) |=> (q_cnt == '0));
endmodule

bind l2_stream_prefetcher pf_checker #(
   .AW(AW), .LVLW(LVLW), .HWM(HWM), .QCW(QCW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_valid   (acc_valid),
   .acc_kind    (acc_kind),
   .acc_miss    (acc_miss),
   .dem_pending (dem_pending),
   .busq_level  (busq_level),
   .pf_ready    (pf_ready),
   .pf_valid    (pf_valid),
   .pf_addr     (pf_addr),
   .q_cnt       (q_cnt)
);

// File: tb/l2_stream_prefetcher_bench.sv
`timescale 1ns/1ps
module l2_stream_prefetcher_bench;
   localparam int HWM = 12;
   localparam int TD  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_kind = '0;
   logic        acc_miss = 1'b0;
   logic        dem_pending = 1'b0;
   logic [3:0]  busq_level = '0;
   logic        pf_ready = 1'b0;
   logic        pf_valid;
   logic [31:0] pf_addr;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   l2_stream_prefetcher u_l2_stream_prefetcher (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_kind(acc_kind), .acc_miss(acc_miss), .dem_pending(dem_pending),
      .busq_level(busq_level), .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
   );

   // reference model state
   bit [25:0] mq [4];
   int        m_cnt;
   bit [25:0] f_nxt [16];
   bit        f_v [16];
   int        f_st [16];
   bit [25:0] b_nxt [4];
   bit        b_v [4];
   int        b_st [4];
   int        stamp;
   bit        m_lastv;
   bit [25:0] m_last;

   task automatic m_reset();
      m_cnt = 0; stamp = 0; m_lastv = 0; m_last = '0;
      for (int i = 0; i < 16; i++) begin f_v[i] = 0; f_nxt[i] = '0; f_st[i] = 0; end
      for (int i = 0; i < 4; i++) begin b_v[i] = 0; b_nxt[i] = '0; b_st[i] = 0; end
   endtask

   function automatic int f_victim();
      int v = -1;
      for (int i = 0; i < 16; i++) if (v < 0 && !f_v[i]) v = i;
      if (v < 0) begin
         v = 0;
         for (int i = 1; i < 16; i++) if (f_st[i] < f_st[v]) v = i;
      end
      return v;
   endfunction

   function automatic int b_victim();
      int v = -1;
      for (int i = 0; i < 4; i++) if (v < 0 && !b_v[i]) v = i;
      if (v < 0) begin
         v = 0;
         for (int i = 1; i < 4; i++) if (b_st[i] < b_st[v]) v = i;
      end
      return v;
   endfunction

   function automatic bit m_inq(bit [25:0] l);
      bit r = 0;
      for (int i = 0; i < m_cnt; i++) if (mq[i] == l) r = 1;
      return r;
   endfunction

   task automatic m_step(bit v, bit [31:0] a, bit [1:0] k, bit ms, bit dem, int lvl, bit rdy);
      bit over, pop, tr, tm, nu, nd, fa, ba, up, dn, sv, av, d0, d1, w0, w1;
      bit [25:0] ln, sl, al;
      int fh, bh, vi;
      over = lvl > HWM;
      pop  = (m_cnt > 0) && !dem && !over && rdy;
      tr   = v && (k != 2'd3);
      tm   = tr && ms;
      ln   = a[31:6];
      fh = -1; bh = -1;
      for (int i = 0; i < 16; i++) if (fh < 0 && f_v[i] && f_nxt[i] == ln) fh = i;
      for (int i = 0; i < 4; i++)  if (bh < 0 && b_v[i] && b_nxt[i] == ln) bh = i;
      nu = m_lastv && (ln > m_last) && ((ln - m_last) <= TD);
      nd = m_lastv && (ln < m_last) && ((m_last - ln) <= TD);
      fa = tm && fh < 0 && bh < 0 && nu;
      ba = tm && fh < 0 && bh < 0 && nd;
      up = 0; dn = 0;
      if (tr && fh >= 0) begin
         f_nxt[fh] = ln + 1; stamp++; f_st[fh] = stamp; up = 1;
      end else if (tr && bh >= 0) begin
         b_nxt[bh] = ln - 1; stamp++; b_st[bh] = stamp; dn = 1;
      end else if (fa) begin
         vi = f_victim(); f_v[vi] = 1; f_nxt[vi] = ln + 1; stamp++; f_st[vi] = stamp; up = 1;
      end else if (ba) begin
         vi = b_victim(); b_v[vi] = 1; b_nxt[vi] = ln - 1; stamp++; b_st[vi] = stamp; dn = 1;
      end
      sl = up ? ln + 1 : ln - 1;
      sv = (up || dn) && (sl[25:6] == ln[25:6]);
      av = tm;
      al = ln ^ 26'd1;
      if (tm) begin m_last = ln; m_lastv = 1; end
      d0 = m_inq(sl);
      d1 = m_inq(al);
      w0 = sv && !over && !d0;
      w1 = av && !over && !d1 && !(sv && al == sl);
      if ((pop || over) && m_cnt > 0) begin
         for (int i = 0; i < 3; i++) mq[i] = mq[i + 1];
         m_cnt--;
      end
      if (w0 && m_cnt < 4) begin mq[m_cnt] = sl; m_cnt++; end
      if (w1 && m_cnt < 4) begin mq[m_cnt] = al; m_cnt++; end
   endtask

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: drive after the falling edge, compare before the rising edge, advance the model
   task automatic cyc(bit v, logic [31:0] a, bit [1:0] k, bit ms, bit dem, int lvl, bit rdy, string tag);
      bit ev;
      @(negedge clk);
      acc_valid = v; acc_addr = a; acc_kind = k; acc_miss = ms;
      dem_pending = dem; busq_level = lvl[3:0]; pf_ready = rdy;
      #8;
      ev = (m_cnt > 0) && !dem && !(lvl > HWM);
      chk(pf_valid == ev, {tag, " valid"}, {31'd0, pf_valid}, {31'd0, ev});
      if (ev) chk(pf_addr == {mq[0], 6'd0}, {tag, " addr"}, pf_addr, {mq[0], 6'd0});
      m_step(v, a, k, ms, dem, lvl, rdy);
   endtask

   // idle cycle with a literal expectation on the port
   task automatic look(bit ev, logic [31:0] ea, string tag);
      @(negedge clk);
      acc_valid = 0; acc_miss = 0; dem_pending = 0; busq_level = 0; pf_ready = 0;
      #8;
      chk(pf_valid == ev, {tag, " literal valid"}, {31'd0, pf_valid}, {31'd0, ev});
      if (ev) chk(pf_addr == ea, {tag, " literal addr"}, pf_addr, ea);
      m_step(0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic miss(logic [31:0] a, bit [1:0] k, string tag);
      cyc(1, a, k, 1, 0, 0, 0, tag);
   endtask

   task automatic drain(string tag);
      for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0, 1, tag);
   endtask

   initial begin
      #4_000_000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit [25:0] up_ptr, dn_ptr, near;
      void'($urandom(32'h5eed_2024));
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      #8;
      chk(pf_valid == 0, "R1 reset idle", {31'd0, pf_valid}, 32'd0);

      // R2 partner line
      miss(32'h0000_4000, 0, "R2");
      look(1, 32'h0000_4040, "R2");
      drain("R2");

      // R3 ascending allocation
      miss(32'h0008_0000, 0, "R3");
      miss(32'h0008_00C0, 0, "R3");
      look(1, 32'h0008_0040, "R3");
      drain("R3");

      // R3 / R10 equal line: no stream, repeated partner filtered
      miss(32'h0009_0000, 0, "R3");
      miss(32'h0009_0000, 0, "R10");
      look(1, 32'h0009_0040, "R10");
      cyc(0, 0, 0, 0, 0, 0, 1, "R10");
      look(0, 0, "R10");

      // R3 too far apart
      miss(32'h0009_4000, 0, "R3");
      miss(32'h0009_4140, 0, "R3");
      drain("R3");

      // R4 advance on a hit at the expected line
      cyc(1, 32'h0008_0100, 0, 0, 0, 0, 0, "R4");
      look(1, 32'h0008_0140, "R4");
      drain("R4");

      // R3 descending allocation
      miss(32'h000A_0000, 0, "R3");
      miss(32'h0009_FF80, 0, "R3");
      drain("R3");

      // R6 page crossing suppressed
      miss(32'h000B_0F80, 0, "R6");
      miss(32'h000B_0FC0, 0, "R6");
      look(1, 32'h000B_0FC0, "R6");
      drain("R6");

      // R7 kinds
      miss(32'h000C_0000, 3, "R7");
      look(0, 0, "R7");
      miss(32'h000D_0000, 1, "R7");
      miss(32'h000D_0040, 2, "R7");
      drain("R7");

      // R8 demand yields
      miss(32'h000E_0000, 0, "R8");
      cyc(0, 0, 0, 0, 1, 0, 1, "R8");
      cyc(0, 0, 0, 0, 1, 0, 1, "R8");
      drain("R8");

      // R9 high-water flush and drop
      miss(32'h000F_0000, 0, "R9");
      miss(32'h000F_1000, 0, "R9");
      cyc(0, 0, 0, 0, 0, 13, 0, "R9");
      cyc(1, 32'h000F_2000, 0, 1, 0, 13, 0, "R9");
      look(0, 0, "R9");

      // R10 full queue drops the newest
      for (int i = 0; i < 5; i++) miss(32'h0010_0000 + i * 32'h1000, 0, "R10");
      drain("R10");

      // R5 descending pool capacity and replacement
      for (int s = 0; s < 5; s++) begin
         miss(32'h0020_0000 + s * 32'h1_0000, 0, "R5");
         miss(32'h0020_0000 + s * 32'h1_0000 - 32'h40, 0, "R5");
         drain("R5");
      end
      cyc(1, 32'h0020_0000 - 32'h80, 0, 0, 0, 0, 0, "R5");
      cyc(1, 32'h0024_0000 - 32'h80, 0, 0, 0, 0, 0, "R5");
      drain("R5");

      // R11 constrained random mix
      up_ptr = 26'h10000; dn_ptr = 26'h20000; near = 26'h30000;
      for (int n = 0; n < 4000; n++) begin
         int r;
         bit [25:0] l;
         bit [1:0] k;
         r = $urandom_range(0, 99);
         if (r < 35) begin
            up_ptr = up_ptr + 26'($urandom_range(1, 2)); l = up_ptr;
         end else if (r < 55) begin
            dn_ptr = dn_ptr - 26'($urandom_range(1, 2)); l = dn_ptr;
         end else if (r < 85) begin
            l = near + 26'($urandom_range(0, 8));
         end else begin
            l = 26'($urandom_range(0, 32'h3FFFFFF));
            if (r > 95) up_ptr = l;
            if (r == 95) dn_ptr = l;
            if (r == 94) near = l;
         end
         k = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
         cyc($urandom_range(0, 9) < 7, {l, 6'($urandom_range(0, 63))}, k,
             $urandom_range(0, 9) < 7, $urandom_range(0, 9) < 2,
             $urandom_range(0, 15), $urandom_range(0, 9) < 6, "R11 mix");
      end
      drain("R11");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule